// File: doc/BRIEF.md
# Stack and Illegal-Fetch Guard

This unit sits beside a small 8-bit processor core. It keeps the data stack pointer and moves it on push, pop, call, interrupt entry and return strobes. It resolves every data read and every instruction fetch against a fixed memory map. Reads that land in holes of the data map return all ones. Fetches beyond the end of program memory return zero.

A fetched zero opcode is the software interrupt. Seeing one sets a sticky pending flag, which software removes with a clear strobe. The two fill values are what catch a runaway stack. If software pops more than it pushed, the return reads two all-ones bytes from the hole just above the stack's reset position. These form program address 0x7FFF, which lies outside program memory and fetches as zero. The software interrupt therefore fires without any dedicated underflow comparator.

Returns take two cycles. During them the unit presents the address of the next stack byte and captures the resolved read data as the low byte and then the high byte. It then presents the 15-bit return address for one cycle.

Top module: `stack_fetch_guard`

## Requirements
- R1: While reset is held and after it is released, stackPtr is 0x6F, swiPending is 0, retValid is 0 and retBusy is 0.
- R2: With no return in progress, the stack pointer changes one cycle after a strobe. callStb or intStb lowers it by 2, pushStb lowers it by 1 and popStb raises it by 1. When several strobes are high together, only one acts, in this order of priority: call, interrupt entry, push, pop.
- R3: The data address splits into a segment (dataAddr[9:8]) and an offset (dataAddr[7:0]). dataOut is 0xFF for these reads: segment 0 at offsets 0x70 to 0x7F, segment 1 at offsets 0x40 to 0x7F, and any address in segment 3. Every other read passes ramRdData through unchanged, in the same cycle.
- R4: fetchOut is 0x00 when fetchAddr is at or above ROM_SIZE (default 0x1000). Otherwise fetchOut equals romRdData, in the same cycle.
- R5: stackAddr always equals stackPtr+1. A retStb sampled while idle starts two busy cycles, and retBusy is high in both. In each busy cycle dataOut is captured and the stack pointer rises by 1. The first capture is the low byte and the second is the high byte. In the cycle after the second busy cycle, retValid is high for one cycle and retAddr is {high[6:0], low}.
- R6: While retBusy is high, push, pop, call, interrupt and return strobes are ignored.
- R7: A fetch with fetchValid high and fetchOut equal to 0x00 sets swiPending in the next cycle. swiPending then stays high until it is cleared.
- R8: clrPendStb clears swiPending in the next cycle. If a zero fetch happens in the same cycle as the clear, the set wins.
- R9: A return issued straight after reset produces retAddr 0x7FFF and leaves stackPtr at 0x71. A valid fetch of that address then raises swiPending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pushStb | input | 1 | Push one byte |
| popStb | input | 1 | Pop one byte |
| callStb | input | 1 | Subroutine call (two bytes) |
| intStb | input | 1 | Interrupt entry (two bytes) |
| retStb | input | 1 | Start a two-byte return |
| clrPendStb | input | 1 | Clear the software-interrupt pending flag |
| fetchValid | input | 1 | An instruction fetch is taking place |
| fetchAddr | input | 15 | Program address of the fetch |
| romRdData | input | 8 | Raw program memory data |
| dataAddr | input | 10 | Data read address (segment and offset) |
| ramRdData | input | 8 | Raw data memory data |
| stackPtr | output | 8 | Current stack pointer |
| stackAddr | output | 8 | Address of the next byte to pop |
| dataOut | output | 8 | Resolved data read value |
| fetchOut | output | 8 | Resolved opcode |
| retAddr | output | 15 | Assembled return address |
| retValid | output | 1 | retAddr is valid this cycle |
| retBusy | output | 1 | A return sequence is in progress |
| swiPending | output | 1 | Software interrupt pending |

## Verification
The hardest condition to reach from the ports is the over-pop chain. The stack must be unbalanced, both popped bytes must come from the all-ones hole, and the assembled address must then be fetched as zero. The bench reaches it by issuing a return directly after reset, with the data address tied to stackAddr as a processor would tie it. It then feeds the produced retAddr back as the next fetch address and checks that the pending flag rises. A second hard case is strobes that arrive during the two busy return cycles. These are driven in the first busy cycle, and the bench confirms that neither the pointer nor the sequencer reacts.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;

  // Strobes from the control unit to the datapath, one cycle each.
  typedef struct packed {
    logic dec2;     // lower pointer by two
    logic dec1;     // lower pointer by one
    logic inc1;     // raise pointer by one
    logic capLo;    // capture low return byte
    logic capHi;    // capture high return byte
    logic setPend;  // zero opcode fetched
    logic clrPend;  // software clear
  } guardCtl_t;

  typedef enum logic [1:0] {
    RET_IDLE = 2'd0,
    RET_LO   = 2'd1,
    RET_HI   = 2'd2
  } retState_e;

endpackage

// File: rtl/sg_memmap.sv
module sg_memmap #(
  parameter int DATA_W         = 8,
  parameter int DADDR_W        = 10,
  parameter int FADDR_W        = 15,
  parameter int ROM_SIZE       = 4096,
  parameter int SEG0_HOLE_LO   = 'h70,
  parameter int SEG0_HOLE_HI   = 'h7F,
  parameter int SEG1_HOLE_LO   = 'h40,
  parameter int SEG1_HOLE_HI   = 'h7F,
  parameter int FIRST_DEAD_SEG = 3
) (
  input  logic [DADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0]  ramRdData,
  input  logic [FADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0]  romRdData,
  output logic [DATA_W-1:0]  dataOut,
  output logic [DATA_W-1:0]  fetchOut
);

  localparam int SEG_W = DADDR_W - 8;
  localparam logic [7:0] H0_LO = 8'(SEG0_HOLE_LO);
  localparam logic [7:0] H0_HI = 8'(SEG0_HOLE_HI);
  localparam logic [7:0] H1_LO = 8'(SEG1_HOLE_LO);
  localparam logic [7:0] H1_HI = 8'(SEG1_HOLE_HI);

  logic [SEG_W-1:0] segment;
  logic [7:0]       offset;
  logic             holeSeg0;
  logic             holeSeg1;
  logic             deadSeg;
  logic             ramUnmapped;
  logic             romUnmapped;

  assign segment = dataAddr[DADDR_W-1:8];
  assign offset  = dataAddr[7:0];

  assign holeSeg0 = (segment == SEG_W'(0)) && (offset >= H0_LO) && (offset <= H0_HI);
  assign holeSeg1 = (segment == SEG_W'(1)) && (offset >= H1_LO) && (offset <= H1_HI);

  generate
    if (FIRST_DEAD_SEG >= (1 << SEG_W)) begin : g_noDeadSeg
      assign deadSeg = 1'b0;
    end else begin : g_deadSeg
      localparam logic [SEG_W-1:0] DEAD_FIRST = SEG_W'(FIRST_DEAD_SEG);
      assign deadSeg = (segment >= DEAD_FIRST);
    end
  endgenerate

  assign ramUnmapped = holeSeg0 | holeSeg1 | deadSeg;
  assign dataOut     = ramUnmapped ? {DATA_W{1'b1}} : ramRdData;

  generate
    if (ROM_SIZE >= (1 << FADDR_W)) begin : g_fullRom
      assign romUnmapped = 1'b0;
    end else begin : g_partRom
      localparam logic [FADDR_W-1:0] ROM_LIMIT = FADDR_W'(ROM_SIZE);
      assign romUnmapped = (fetchAddr >= ROM_LIMIT);
    end
  endgenerate

  assign fetchOut = romUnmapped ? {DATA_W{1'b0}} : romRdData;

endmodule

// File: rtl/sg_control.sv
module sg_control
  import stack_guard_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushStb,
  input  logic              popStb,
  input  logic              callStb,
  input  logic              intStb,
  input  logic              retStb,
  input  logic              clrPendStb,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchOp,
  output guardCtl_t         ctl,
  output logic              retBusy
);

  localparam logic [DATA_W-1:0] SWI_OPCODE = '0;

  retState_e state;
  retState_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= RET_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      RET_IDLE: begin
        if (callStb || intStb) ctl.dec2 = 1'b1;
        else if (pushStb)      ctl.dec1 = 1'b1;
        else if (popStb)       ctl.inc1 = 1'b1;
        else if (retStb)       stateNext = RET_LO;
      end
      RET_LO: begin
        ctl.capLo = 1'b1;
        ctl.inc1  = 1'b1;
        stateNext = RET_HI;
      end
      RET_HI: begin
        ctl.capHi = 1'b1;
        ctl.inc1  = 1'b1;
        stateNext = RET_IDLE;
      end
      default: stateNext = RET_IDLE;
    endcase
    ctl.setPend = fetchValid && (fetchOp == SWI_OPCODE);
    ctl.clrPend = clrPendStb;
  end

  assign retBusy = (state != RET_IDLE);

endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import stack_guard_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               SP_W     = 8,
  parameter int               FADDR_W  = 15,
  parameter logic [SP_W-1:0]  SP_RESET = 8'h6F
) (
  input  logic               clk,
  input  logic               rstN,
  input  guardCtl_t          ctl,
  input  logic [DATA_W-1:0]  rdByte,
  output logic [SP_W-1:0]    stackPtr,
  output logic [SP_W-1:0]    stackAddr,
  output logic [FADDR_W-1:0] retAddr,
  output logic               retValid,
  output logic               swiPending
);

  localparam int HI_W = FADDR_W - DATA_W;

  logic [SP_W-1:0]   spReg;
  logic [DATA_W-1:0] loByte;
  logic [HI_W-1:0]   hiByte;
  logic              retValidReg;
  logic              pendReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spReg <= SP_RESET;
    end else if (ctl.dec2) begin
      spReg <= spReg - SP_W'(2);
    end else if (ctl.dec1) begin
      spReg <= spReg - SP_W'(1);
    end else if (ctl.inc1) begin
      spReg <= spReg + SP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte      <= '0;
      hiByte      <= '0;
      retValidReg <= 1'b0;
    end else begin
      if (ctl.capLo) loByte <= rdByte;
      if (ctl.capHi) hiByte <= rdByte[HI_W-1:0];
      retValidReg <= ctl.capHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pendReg <= 1'b0;
    else if (ctl.setPend) pendReg <= 1'b1;
    else if (ctl.clrPend) pendReg <= 1'b0;
  end

  assign stackPtr   = spReg;
  assign stackAddr  = spReg + SP_W'(1);
  assign retAddr    = {hiByte, loByte};
  assign retValid   = retValidReg;
  assign swiPending = pendReg;

endmodule

// File: rtl/stack_fetch_guard.sv
module stack_fetch_guard
  import stack_guard_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              SP_W     = 8,
  parameter int              DADDR_W  = 10,
  parameter int              FADDR_W  = 15,
  parameter int              ROM_SIZE = 4096,
  parameter logic [SP_W-1:0] SP_RESET = 8'h6F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushStb,
  input  logic               popStb,
  input  logic               callStb,
  input  logic               intStb,
  input  logic               retStb,
  input  logic               clrPendStb,
  input  logic               fetchValid,
  input  logic [FADDR_W-1:0] fetchAddr,
  input  logic [DATA_W-1:0]  romRdData,
  input  logic [DADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0]  ramRdData,
  output logic [SP_W-1:0]    stackPtr,
  output logic [SP_W-1:0]    stackAddr,
  output logic [DATA_W-1:0]  dataOut,
  output logic [DATA_W-1:0]  fetchOut,
  output logic [FADDR_W-1:0] retAddr,
  output logic               retValid,
  output logic               retBusy,
  output logic               swiPending
);

  guardCtl_t ctl;

  sg_memmap #(
    .DATA_W  (DATA_W),
    .DADDR_W (DADDR_W),
    .FADDR_W (FADDR_W),
    .ROM_SIZE(ROM_SIZE)
  ) u_memmap (
    .dataAddr (dataAddr),
    .ramRdData(ramRdData),
    .fetchAddr(fetchAddr),
    .romRdData(romRdData),
    .dataOut  (dataOut),
    .fetchOut (fetchOut)
  );

  sg_control #(
    .DATA_W(DATA_W)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .pushStb   (pushStb),
    .popStb    (popStb),
    .callStb   (callStb),
    .intStb    (intStb),
    .retStb    (retStb),
    .clrPendStb(clrPendStb),
    .fetchValid(fetchValid),
    .fetchOp   (fetchOut),
    .ctl       (ctl),
    .retBusy   (retBusy)
  );

  sg_datapath #(
    .DATA_W  (DATA_W),
    .SP_W    (SP_W),
    .FADDR_W (FADDR_W),
    .SP_RESET(SP_RESET)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rdByte    (dataOut),
    .stackPtr  (stackPtr),
    .stackAddr (stackAddr),
    .retAddr   (retAddr),
    .retValid  (retValid),
    .swiPending(swiPending)
  );

endmodule

// File: rtl/stack_fetch_guard_chk.sv
module stack_fetch_guard_chk #(
  parameter int              DATA_W   = 8,
  parameter int              SP_W     = 8,
  parameter int              DADDR_W  = 10,
  parameter int              FADDR_W  = 15,
  parameter int              ROM_SIZE = 4096,
  parameter logic [SP_W-1:0] SP_RESET = 8'h6F
) (
  input logic               clk,
  input logic               rstN,
  input logic               pushStb,
  input logic               callStb,
  input logic               intStb,
  input logic               retStb,
  input logic               clrPendStb,
  input logic               fetchValid,
  input logic [FADDR_W-1:0] fetchAddr,
  input logic [DADDR_W-1:0] dataAddr,
  input logic [SP_W-1:0]    stackPtr,
  input logic [DATA_W-1:0]  dataOut,
  input logic [DATA_W-1:0]  fetchOut,
  input logic               retValid,
  input logic               retBusy,
  input logic               swiPending
);

  // R1: pointer is at its reset value during and right after reset
  p_sp_reset_r1: assert property (@(posedge clk)
    !rstN |=> (stackPtr == SP_RESET));

  // R2: call or interrupt entry lowers the pointer by two
  p_call_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (callStb || intStb) && !retBusy |=> stackPtr == $past(stackPtr) - SP_W'(2));

  // R2: push alone lowers the pointer by one
  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    pushStb && !callStb && !intStb && !retBusy |=> stackPtr == $past(stackPtr) - SP_W'(1));

  // R3: segment three and above reads as all ones
  p_dead_seg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataAddr[DADDR_W-1:8] >= (DADDR_W-8)'(3)) |-> dataOut == {DATA_W{1'b1}});

  // R4: fetch past the end of program memory reads as zero
  p_rom_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAddr >= FADDR_W'(ROM_SIZE)) |-> fetchOut == '0);

  // R5: an accepted return runs two busy cycles then presents the address
  p_ret_seq_r5: assert property (@(posedge clk) disable iff (!rstN)
    retStb && !retBusy && !callStb && !intStb && !pushStb
      |=> retBusy ##1 retBusy ##1 (retValid && !retBusy));

  // R6: during a return the pointer only steps up by one per cycle
  p_busy_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    retBusy |=> stackPtr == $past(stackPtr) + SP_W'(1));

  // R7: a zero opcode fetch raises the pending flag
  p_swi_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && (fetchOut == '0) |=> swiPending);

  // R7: the flag holds until cleared
  p_swi_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    swiPending && !clrPendStb |=> swiPending);

  // R8: a clear with no concurrent zero fetch drops the flag
  p_swi_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrPendStb && !(fetchValid && (fetchOut == '0)) |=> !swiPending);

endmodule

bind stack_fetch_guard stack_fetch_guard_chk #(
  .DATA_W  (DATA_W),
  .SP_W    (SP_W),
  .DADDR_W (DADDR_W),
  .FADDR_W (FADDR_W),
  .ROM_SIZE(ROM_SIZE),
  .SP_RESET(SP_RESET)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pushStb   (pushStb),
  .callStb   (callStb),
  .intStb    (intStb),
  .retStb    (retStb),
  .clrPendStb(clrPendStb),
  .fetchValid(fetchValid),
  .fetchAddr (fetchAddr),
  .dataAddr  (dataAddr),
  .stackPtr  (stackPtr),
  .dataOut   (dataOut),
  .fetchOut  (fetchOut),
  .retValid  (retValid),
  .retBusy   (retBusy),
  .swiPending(swiPending)
);

// File: tb/test_stack_fetch_guard.sv
module test_stack_fetch_guard;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pushStb, popStb, callStb, intStb, retStb, clrPendStb;
  logic        fetchValid;
  logic [14:0] fetchAddr;
  logic [7:0]  romRdData;
  logic [9:0]  dataAddr;
  logic [9:0]  addrDrv;
  logic        followStack;
  logic [7:0]  ramRdData;
  logic [7:0]  stackPtr, stackAddr, dataOut, fetchOut;
  logic [14:0] retAddr;
  logic        retValid, retBusy, swiPending;

  logic [7:0] ram [256];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dataAddr  = followStack ? {2'b00, stackAddr} : addrDrv;
  assign ramRdData = ram[dataAddr[7:0]];

  stack_fetch_guard i_stack_fetch_guard (
    .clk(clk), .rstN(rstN),
    .pushStb(pushStb), .popStb(popStb), .callStb(callStb), .intStb(intStb),
    .retStb(retStb), .clrPendStb(clrPendStb),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .romRdData(romRdData),
    .dataAddr(dataAddr), .ramRdData(ramRdData),
    .stackPtr(stackPtr), .stackAddr(stackAddr), .dataOut(dataOut),
    .fetchOut(fetchOut), .retAddr(retAddr), .retValid(retValid),
    .retBusy(retBusy), .swiPending(swiPending)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    pushStb = 0; popStb = 0; callStb = 0; intStb = 0; retStb = 0;
    clrPendStb = 0; fetchValid = 0; fetchAddr = '0; romRdData = 8'h11;
    addrDrv = '0; followStack = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    clearInputs();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    clearInputs();
    rstN = 0;
    @(negedge clk);
    chk("R1", "sp in reset", stackPtr, 8'h6F);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "sp after reset", stackPtr, 8'h6F);
    chk("R1", "pending", swiPending, 0);
    chk("R1", "retValid", retValid, 0);
    chk("R1", "retBusy", retBusy, 0);
  endtask

  task automatic t_stack_ops();
    doReset();
    pushStb = 1; @(negedge clk); pushStb = 0;
    chk("R2", "push", stackPtr, 8'h6E);
    popStb = 1; @(negedge clk); popStb = 0;
    chk("R2", "pop", stackPtr, 8'h6F);
    callStb = 1; @(negedge clk); callStb = 0;
    chk("R2", "call", stackPtr, 8'h6D);
    intStb = 1; @(negedge clk); intStb = 0;
    chk("R2", "int entry", stackPtr, 8'h6B);
    callStb = 1; pushStb = 1; @(negedge clk); callStb = 0; pushStb = 0;
    chk("R2", "call beats push", stackPtr, 8'h69);
    pushStb = 1; popStb = 1; @(negedge clk); pushStb = 0; popStb = 0;
    chk("R2", "push beats pop", stackPtr, 8'h68);
    chk("R5", "stackAddr", stackAddr, 8'h69);
  endtask

  task automatic t_ram_map();
    doReset();
    addrDrv = 10'h050; #1; chk("R3", "seg0 mapped", dataOut, ram[8'h50]);
    addrDrv = 10'h06F; #1; chk("R3", "seg0 below hole", dataOut, ram[8'h6F]);
    addrDrv = 10'h070; #1; chk("R3", "seg0 hole start", dataOut, 8'hFF);
    addrDrv = 10'h07F; #1; chk("R3", "seg0 hole end", dataOut, 8'hFF);
    addrDrv = 10'h080; #1; chk("R3", "seg0 above hole", dataOut, ram[8'h80]);
    addrDrv = 10'h13F; #1; chk("R3", "seg1 below hole", dataOut, ram[8'h3F]);
    addrDrv = 10'h140; #1; chk("R3", "seg1 hole start", dataOut, 8'hFF);
    addrDrv = 10'h17F; #1; chk("R3", "seg1 hole end", dataOut, 8'hFF);
    addrDrv = 10'h180; #1; chk("R3", "seg1 upper", dataOut, ram[8'h80]);
    addrDrv = 10'h200; #1; chk("R3", "seg2", dataOut, ram[8'h00]);
    addrDrv = 10'h305; #1; chk("R3", "seg3", dataOut, 8'hFF);
  endtask

  task automatic t_rom_map();
    doReset();
    romRdData = 8'h77;
    fetchAddr = 15'h0FFF; #1; chk("R4", "last rom byte", fetchOut, 8'h77);
    fetchAddr = 15'h1000; #1; chk("R4", "first unmapped", fetchOut, 8'h00);
    fetchAddr = 15'h7FFF; #1; chk("R4", "top unmapped", fetchOut, 8'h00);
    fetchAddr = 15'h0000; #1; chk("R4", "first rom byte", fetchOut, 8'h77);
  endtask

  task automatic t_return();
    doReset();
    callStb = 1; @(negedge clk); callStb = 0;
    ram[8'h6E] = 8'h34;
    ram[8'h6F] = 8'hD2;
    followStack = 1;
    retStb = 1; @(negedge clk); retStb = 0;
    chk("R5", "busy first", retBusy, 1);
    chk("R5", "stackAddr lo", stackAddr, 8'h6E);
    @(negedge clk);
    chk("R5", "busy second", retBusy, 1);
    chk("R5", "stackAddr hi", stackAddr, 8'h6F);
    @(negedge clk);
    chk("R5", "retValid", retValid, 1);
    chk("R5", "retAddr", retAddr, 15'h5234);
    chk("R5", "sp after ret", stackPtr, 8'h6F);
    chk("R5", "idle after", retBusy, 0);
    @(negedge clk);
    chk("R5", "retValid one cycle", retValid, 0);
    followStack = 0;
  endtask

  task automatic t_busy_ignore();
    doReset();
    followStack = 1;
    retStb = 1; @(negedge clk); retStb = 0;
    pushStb = 1; callStb = 1; retStb = 1;
    @(negedge clk);
    pushStb = 0; callStb = 0; retStb = 0;
    chk("R6", "sp mid-return", stackPtr, 8'h70);
    @(negedge clk);
    chk("R6", "sp end", stackPtr, 8'h71);
    chk("R6", "retValid", retValid, 1);
    @(negedge clk);
    chk("R6", "no second return", retBusy, 0);
    chk("R6", "sp unchanged", stackPtr, 8'h71);
    followStack = 0;
  endtask

  task automatic t_swi();
    doReset();
    fetchValid = 1; fetchAddr = 15'h0100; romRdData = 8'h12;
    @(negedge clk);
    chk("R7", "nonzero fetch", swiPending, 0);
    romRdData = 8'h00;
    @(negedge clk);
    fetchValid = 0; romRdData = 8'h12;
    chk("R7", "zero fetch sets", swiPending, 1);
    repeat (3) @(negedge clk);
    chk("R7", "held", swiPending, 1);
    clrPendStb = 1; @(negedge clk); clrPendStb = 0;
    chk("R8", "clear", swiPending, 0);
    clrPendStb = 1; fetchValid = 1; fetchAddr = 15'h1234;
    @(negedge clk);
    clrPendStb = 0; fetchValid = 0; fetchAddr = 15'h0100;
    chk("R8", "set beats clear", swiPending, 1);
  endtask

  task automatic t_overpop();
    doReset();
    followStack = 1;
    retStb = 1; @(negedge clk); retStb = 0;
    @(negedge clk); @(negedge clk);
    chk("R9", "overpop retAddr", retAddr, 15'h7FFF);
    chk("R9", "overpop sp", stackPtr, 8'h71);
    followStack = 0;
    chk("R9", "pending before fetch", swiPending, 0);
    fetchValid = 1; fetchAddr = retAddr; romRdData = 8'hAB;
    @(negedge clk);
    fetchValid = 0;
    chk("R9", "pending after fetch", swiPending, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i) ^ 8'h3C;
    rstN = 0;
    clearInputs();
    t_reset();
    t_stack_ops();
    t_ram_map();
    t_rom_map();
    t_return();
    t_busy_ignore();
    t_swi();
    t_overpop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule